// File: doc/BRIEF.md
# Bit Pattern Repeat Generator

This block builds a full word by tiling a short bit pattern across it. The pattern is the low `period` bits of the operand. Copies are laid down starting at bit 0 and continue upward. When the period does not divide the word width, the final copy is cut off at the most significant bit. A typical use is making masks at run time, for example alternating groups of ones and zeros, without storing constants.

The datapath is combinational. It seeds the pattern and then runs log2(WIDTH) doubling stages, each of which ORs the word with a copy of itself shifted up by the current run length. An optional output register follows the datapath. With the default setting, the result, the error flag and the valid strobe appear one clock after the input strobe and then hold until the next strobe.

A period of zero has no meaning. It raises the error flag and yields an all-zero result.

Top module: `bit_repeat_gen`

## Requirements
- R1: For a period L with 1 <= L < WIDTH, result bit i equals operand bit (i mod L) for every i in 0..WIDTH-1, including a truncated top copy when L does not divide WIDTH (e.g. operand 0xC, period 4 at 32 bits gives 0xCCCCCCCC).
- R2: Operand bits at positions L and above have no effect on the result.
- R3: Any period value of WIDTH or more, up to the field's maximum, returns the operand unchanged.
- R4: A period of zero sets the error flag and forces the result to zero.
- R5: The error flag is low for every nonzero period.
- R6: With the output register enabled, out_valid equals in_valid delayed by one clock, and the result and error flag for an accepted input appear in that same cycle.
- R7: While in_valid is low, the registered result and error flag keep their last values whatever the operand and period do.
- R8: After synchronous reset, out_valid, result and the error flag are all zero.
- R9: A period of 1 replicates operand bit 0 into every bit of the result.
- R10: Period 2k with operand (1<<k)-1 yields the alternating mask with runs of k bits (0x55555555, 0x33333333, 0x0F0F0F0F, 0x00FF00FF, 0x0000FFFF at 32 bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input strobe; operand and period are taken in this cycle |
| operand | input | WIDTH | Word whose low bits hold the pattern |
| period | input | LEN_W = clog2(WIDTH+1) | Pattern length in bits |
| out_valid | output | 1 | Result strobe |
| result | output | WIDTH | Tiled pattern |
| len_err | output | 1 | Set when the period was zero |

## Verification
The bench targets periods that do not divide the width, such as 3, 5, 7 and 31. A design that ran out of doubling stages, or that sized a shift amount too narrowly, would leave zeros at the top of the word or wrap a copy back down. Operands carrying junk above the period show whether the seed mask is missing, which would OR stray bits into the result. Periods of exactly WIDTH and above it, up to the field maximum, check that a long period returns the operand and does not alias through a truncated shift. A period of zero checks that the error flag fires and the output is cleared. Idle cycles with changing inputs show whether the output register captures data when no strobe is present.

// File: rtl/bitrep_pkg.sv
package bitrep_pkg;

    // Width of the period field: must hold 0..w
    function automatic int unsigned len_bits(input int unsigned w);
        return $clog2(w + 1);
    endfunction

    // Number of doubling stages so that 1 * 2^steps >= w
    function automatic int unsigned doubling_steps(input int unsigned w);
        return (w < 2) ? 1 : $clog2(w);
    endfunction

    // How the period relates to the word
    typedef enum logic [1:0] {
        SPAN_NONE  = 2'd0,
        SPAN_PART  = 2'd1,
        SPAN_WHOLE = 2'd2
    } span_e;

    // Control that travels with the data word
    typedef struct packed {
        logic valid;
        logic err;
    } rep_flags_t;

endpackage

// File: rtl/bitrep_decode.sv
module bitrep_decode
    import bitrep_pkg::*;
#(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned LEN_W = len_bits(WIDTH)
) (
    input  logic [WIDTH-1:0] operand,
    input  logic [LEN_W-1:0] period,
    output span_e            span,
    output logic [WIDTH-1:0] seed
);

    logic [WIDTH-1:0] keep;

    // Bit i belongs to the pattern when i < period; a period >= WIDTH keeps all
    for (genvar i = 0; i < WIDTH; i++) begin : g_keep
        assign keep[i] = (LEN_W'(i) < period);
    end

    always_comb begin
        if (period == '0)
            span = SPAN_NONE;
        else if (period >= LEN_W'(WIDTH))
            span = SPAN_WHOLE;
        else
            span = SPAN_PART;
    end

    assign seed = operand & keep;

endmodule

// File: rtl/bitrep_stage.sv
module bitrep_stage #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned LEN_W = 6,
    parameter int unsigned STEP  = 0,
    parameter int unsigned SH_W  = LEN_W + STEP + 1
) (
    input  logic [WIDTH-1:0] pat_in,
    input  logic [LEN_W-1:0] period,
    output logic [WIDTH-1:0] pat_out
);

    // After STEP stages the filled run is period * 2^STEP bits long
    logic [SH_W-1:0] run_len;

    assign run_len = SH_W'(period) << STEP;
    assign pat_out = pat_in | (pat_in << run_len);

endmodule

// File: rtl/bitrep_outreg.sv
module bitrep_outreg
    import bitrep_pkg::*;
#(
    parameter int unsigned WIDTH   = 32,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  rep_flags_t       flags_in,
    input  logic [WIDTH-1:0] data_in,
    output rep_flags_t       flags_out,
    output logic [WIDTH-1:0] data_out
);

    if (REG_OUT) begin : g_reg
        rep_flags_t       flags_q;
        logic [WIDTH-1:0] data_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                flags_q <= '0;
                data_q  <= '0;
            end else begin
                flags_q.valid <= flags_in.valid;
                if (flags_in.valid) begin
                    flags_q.err <= flags_in.err;
                    data_q      <= data_in;
                end
            end
        end

        assign flags_out = flags_q;
        assign data_out  = data_q;
    end else begin : g_comb
        assign flags_out = flags_in;
        assign data_out  = data_in;
    end

endmodule

// File: rtl/bit_repeat_gen.sv
module bit_repeat_gen
    import bitrep_pkg::*;
#(
    parameter int unsigned WIDTH   = 32,
    parameter bit          REG_OUT = 1'b1,
    parameter int unsigned LEN_W   = len_bits(WIDTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] operand,
    input  logic [LEN_W-1:0] period,
    output logic             out_valid,
    output logic [WIDTH-1:0] result,
    output logic             len_err
);

    localparam int unsigned STEPS = doubling_steps(WIDTH);

    span_e            span;
    logic [WIDTH-1:0] chain [0:STEPS];
    rep_flags_t       flags_c;
    rep_flags_t       flags_o;

    bitrep_decode #(.WIDTH(WIDTH), .LEN_W(LEN_W)) u_decode (
        .operand (operand),
        .period  (period),
        .span    (span),
        .seed    (chain[0])
    );

    for (genvar k = 0; k < STEPS; k++) begin : g_dbl
        bitrep_stage #(.WIDTH(WIDTH), .LEN_W(LEN_W), .STEP(k)) u_stage (
            .pat_in  (chain[k]),
            .period  (period),
            .pat_out (chain[k+1])
        );
    end

    assign flags_c.valid = in_valid;
    assign flags_c.err   = (span == SPAN_NONE);

    bitrep_outreg #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_out (
        .clk       (clk),
        .rst       (rst),
        .flags_in  (flags_c),
        .data_in   (chain[STEPS]),
        .flags_out (flags_o),
        .data_out  (result)
    );

    assign out_valid = flags_o.valid;
    assign len_err   = flags_o.err;

endmodule

// File: rtl/bit_repeat_chk.sv
module bit_repeat_chk
    import bitrep_pkg::*;
#(
    parameter int unsigned WIDTH   = 32,
    parameter bit          REG_OUT = 1'b1,
    parameter int unsigned LEN_W   = len_bits(WIDTH)
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [WIDTH-1:0] operand,
    input logic [LEN_W-1:0] period,
    input logic             out_valid,
    input logic [WIDTH-1:0] result,
    input logic             len_err
);

    if (REG_OUT) begin : g_seq
        assert_valid_follow_R6: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_valid);
        assert_valid_quiet_R6: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> !out_valid);
        assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> ($stable(result) && $stable(len_err)));
        assert_zero_len_R4: assert property (@(posedge clk) disable iff (rst)
            (in_valid && period == '0) |=> (len_err && result == '0));
        assert_no_false_err_R5: assert property (@(posedge clk) disable iff (rst)
            (in_valid && period != '0) |=> !len_err);
        assert_full_passthru_R3: assert property (@(posedge clk) disable iff (rst)
            (in_valid && period >= LEN_W'(WIDTH)) |=> (result == $past(operand)));
        assert_bit0_R1: assert property (@(posedge clk) disable iff (rst)
            (in_valid && period != '0) |=> (result[0] == $past(operand[0])));
    end

endmodule

bind bit_repeat_gen bit_repeat_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .operand   (operand),
    .period    (period),
    .out_valid (out_valid),
    .result    (result),
    .len_err   (len_err)
);

// File: tb/tb_bit_repeat_gen.sv
`timescale 1ns/1ps
module tb_bit_repeat_gen;

    localparam int unsigned W  = 32;
    localparam int unsigned LW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [W-1:0]  operand = '0;
    logic [LW-1:0] period = '0;
    logic          out_valid;
    logic [W-1:0]  result;
    logic          len_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [W:0]   sb_q [$];   // {err, data}
    logic [W-1:0] rng = 32'h1234_5678;

    always #10 clk = ~clk;    // 50 MHz

    bit_repeat_gen #(.WIDTH(W), .REG_OUT(1'b1)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .operand(operand),
        .period(period), .out_valid(out_valid), .result(result), .len_err(len_err)
    );

    function automatic logic [W-1:0] model(input logic [W-1:0] op, input int len);
        logic [W-1:0] r;
        int eff;
        r = '0;
        if (len == 0) return r;
        eff = (len > W) ? W : len;
        for (int i = 0; i < W; i++) r[i] = op[i % eff];
        return r;
    endfunction

    function automatic logic [W-1:0] next_rng(input logic [W-1:0] s);
        logic [W-1:0] t;
        t = s ^ (s << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

    task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual err=%0b data=%h expected err=%0b data=%h",
                     req, act[W], act[W-1:0], exp[W], exp[W-1:0]);
        end
    endtask

    // Driver: one accepted input per call, expected item pushed to the scoreboard
    task automatic apply(input logic [W-1:0] op, input int len);
        @(negedge clk);
        in_valid = 1'b1;
        operand  = op;
        period   = LW'(len);
        sb_q.push_back({(len == 0), model(op, len)});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            rng      = next_rng(rng);
            operand  = rng;
            period   = rng[LW-1:0];
        end
    endtask

    // Monitor: compare every output strobe with the scoreboard head
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && out_valid) begin
                if (sb_q.size() == 0) begin
                    check("R6 unexpected strobe", {1'b1, {W{1'b0}}}, {1'b0, {W{1'b0}}});
                end else begin
                    logic [W:0] exp;
                    exp = sb_q.pop_front();
                    // R1 R2 R3 R4 R5 R9 R10 via the model
                    check("R1-data/R6-timing", {len_err, result}, exp);
                end
            end
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R6 watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [W:0] held;
        // R8: reset state
        repeat (3) @(negedge clk);
        check("R8 reset", {len_err, result}, '0);
        check("R8 reset valid", {W'(0), out_valid}, '0);
        rst = 1'b0;

        // R1 example and non-divisor periods
        apply(32'h0000_000C, 4);
        apply(32'h0000_0005, 3);
        apply(32'h0000_0013, 5);
        apply(32'h0000_0049, 7);
        apply(32'h5555_4321, 31);
        // R2: upper junk ignored
        apply(32'hFFFF_FFF5, 3);
        apply(32'hABCD_EF0C, 4);
        // R9: period one
        apply(32'h0000_0001, 1);
        apply(32'hFFFF_FFFE, 1);
        // R10: alternating masks
        apply(32'h0000_0001, 2);
        apply(32'h0000_0003, 4);
        apply(32'h0000_000F, 8);
        apply(32'h0000_00FF, 16);
        apply(32'h0000_FFFF, 32);
        // R3: long periods
        apply(32'hDEAD_BEEF, 32);
        apply(32'h1357_9BDF, 33);
        apply(32'h0F1E_2D3C, 63);
        // R4: zero period
        apply(32'hFFFF_FFFF, 0);
        // R5: nonzero right after zero
        apply(32'h0000_0002, 2);
        idle(2);

        // R7: hold while idle
        apply(32'h0000_0006, 3);
        @(negedge clk);
        held = {len_err, result};
        in_valid = 1'b0; operand = 32'hFFFF_FFFF; period = '0;
        @(negedge clk);
        check("R7 hold", {len_err, result}, held);
        check("R6 idle no strobe", {W'(0), out_valid}, '0);
        idle(1);
        check("R7 hold again", {len_err, result}, held);

        // R1/R2/R3/R4 random sweep, with gaps
        for (int n = 0; n < 60; n++) begin
            int len;
            rng = next_rng(rng);
            len = int'(rng[W-1:W-6]) % 40;
            apply(rng, len);
            if (rng[3]) idle(1);
        end
        idle(3);
        check("R6 scoreboard drained", {W'(0), sb_q.size() != 0}, '0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule